// File: doc/BRIEF.md
# Lock-Step Macroblock Stage Scheduler

This block sequences the stages of a video encoder that work on different macroblocks at once. In the default arrangement there are four slots, always visited in this order:

1. Slot 0: integer-pel motion search.
2. Slot 1: fractional-pel refinement.
3. Slot 2: intra prediction together with the forward/inverse transform and quantisation loop. This stage also writes the reconstructed upper-row pixels to a local line store, so that later macroblock rows can use them.
4. Slot 3: loop filtering and entropy coding, which share this last slot.

Each slot has a one-cycle start pulse from the scheduler and a one-cycle done pulse back. The scheduler holds the macroblock index of every slot. It moves all slots forward together once every occupied slot has reported done.

A frame begins with a start pulse that carries the frame length in macroblocks and the pipeline arrangement. The scheduler fills the pipeline one slot per advance. In steady state it keeps four consecutive macroblocks in flight. At the end it drains the pipeline with no new input, and it pulses a frame-done flag once the last macroblock leaves the final slot.

A two-slot arrangement is also available. In that case slot 0 runs motion search and slot 1 runs everything else on the previous macroblock. Every advance flips a buffer-select bit at each slot boundary, so the stage datapaths can ping-pong their hand-off buffers.

The interface is control only: plain pulses and levels, with no streamed data and therefore no back-pressure. The stage datapaths are outside the block.

Top module: `mb_pipe_sched`

## Requirements
- R1: After reset, `stage_start`, `stage_busy`, `buf_sel`, `frame_busy` and `frame_done` are all zero.
- R2: `frame_start` is taken only when no frame is in progress and `frame_mbs` is nonzero. When taken, it captures the frame length and the arrangement (`two_stage` = 0 selects four slots, 1 selects two), and `frame_busy` reads 1 from the next cycle. A pulse that arrives while a frame is in progress, or with a length of zero, has no effect. `two_stage` is ignored outside the cycle in which a frame is accepted.
- R3: All occupied slots advance in the same cycle, and only once each of them has reported done. The resulting start pulses appear two cycles after the cycle in which the last outstanding done was presented. The first starts of a frame appear two cycles after the accepted `frame_start`.
- R4: Each macroblock index from 0 to N-1 passes through each active slot exactly once, in ascending order, and in slot order 0 to 3. While a slot is busy, its field of `stage_mb` (bits `i*MBW` upward for slot i) shows the index it holds.
- R5: In four-slot mode with N of at least 4, there is an advance that starts all four slots at once, holding indices k, k-1, k-2 and k-3 in slots 0 to 3.
- R6: In two-slot mode, only slots 0 and 1 are ever started or marked busy.
- R7: A done pulse counts only from a busy slot, and only after the cycle of its start pulse. A done pulse from an idle slot, or in the start cycle, is ignored.
- R8: During fill, one more slot becomes occupied per advance. During drain, no index beyond N-1 is issued. When `frame_done` pulses, no slot is busy.
- R9: Every advance flips all three `buf_sel` bits. This includes the final advance that empties the pipeline, so a frame of N macroblocks flips them N+4 times in four-slot mode and N+2 times in two-slot mode.
- R10: `frame_done` is a single-cycle pulse that appears two cycles after the last slot's final done. After it, a new frame can be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| frame_start | input | 1 | Pulse that requests a new frame |
| frame_mbs | input | MBW | Frame length in macroblocks, taken with `frame_start` |
| two_stage | input | 1 | Arrangement select, taken with `frame_start` |
| stage_done | input | 4 | Per-slot completion pulse |
| stage_start | output | 4 | Per-slot start pulse |
| stage_busy | output | 4 | Slot holds a macroblock |
| stage_mb | output | 4*MBW | Macroblock index per slot, slot i at bits `i*MBW` upward |
| buf_sel | output | 3 | Ping-pong select per slot boundary |
| frame_busy | output | 1 | A frame is in progress |
| frame_done | output | 1 | Pulse after the last macroblock leaves |

## Verification
Two kinds of event can land on the same advance. One is the arrival of the last outstanding done from some slot. The other is an edge of the frame itself: the advance that loads the first index, or the one that empties the final slot and raises `frame_done`.

The bench draws stage durations at random, so the slot that finishes last changes from one advance to the next. It then checks that the starts, and the final `frame_done`, each land exactly two cycles after the last done, whichever slot that was. Done pulses presented in a start cycle, noise on idle slots, and a repeated `frame_start` in the middle of a frame are mixed in. The bench confirms these move neither the index sequence nor that timing.

// File: rtl/mbp_pkg.sv
package mbp_pkg;
  localparam int NUM_SLOTS = 4;
  localparam int NUM_BOUNDS = NUM_SLOTS - 1;
  localparam int SHORT_SLOTS = 2;

  typedef enum logic {
    PIPE_FULL  = 1'b0,
    PIPE_SHORT = 1'b1
  } pipe_mode_e;
endpackage

// File: rtl/mbp_slot.sv
module mbp_slot #(
  parameter int MBW = 14
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           adv,
  input  logic           in_occ,
  input  logic [MBW-1:0] in_mb,
  input  logic           done,
  output logic           occ,
  output logic [MBW-1:0] mb,
  output logic           fin,
  output logic           start
);
  logic accept_done;
  assign accept_done = done & occ & ~fin & ~start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ   <= 1'b0;
      mb    <= '0;
      fin   <= 1'b0;
      start <= 1'b0;
    end else if (adv) begin
      occ   <= in_occ;
      mb    <= in_occ ? in_mb : '0;
      fin   <= 1'b0;
      start <= in_occ;
    end else begin
      start <= 1'b0;
      if (accept_done) fin <= 1'b1;
    end
  end

  // R7
  start_cycle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !fin);

  // R3
  fin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !adv) |=> fin);
endmodule

// File: rtl/mbp_frame_ctrl.sv
module mbp_frame_ctrl
  import mbp_pkg::*;
#(
  parameter int MBW = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_start,
  input  logic [MBW-1:0]       frame_mbs,
  input  logic                 two_stage,
  input  logic [NUM_SLOTS-1:0] occ,
  input  logic [NUM_SLOTS-1:0] fin,
  input  logic                 tail_occ,
  input  logic [MBW-1:0]       tail_mb,
  output logic                 adv,
  output logic                 active,
  output pipe_mode_e           mode_q,
  output logic [MBW-1:0]       next_mb,
  output logic                 feed_occ,
  output logic                 frame_done
);
  logic [MBW-1:0] total_q;
  logic           all_fin;
  logic           finish;
  logic           accept;

  assign all_fin  = &(~occ | fin);
  assign adv      = active & all_fin;
  assign feed_occ = active & (next_mb < total_q);
  assign finish   = tail_occ & (tail_mb == total_q - MBW'(1));
  assign accept   = ~active & frame_start & (frame_mbs != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      total_q    <= '0;
      next_mb    <= '0;
      mode_q     <= PIPE_FULL;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (accept) begin
        active  <= 1'b1;
        total_q <= frame_mbs;
        next_mb <= '0;
        mode_q  <= two_stage ? PIPE_SHORT : PIPE_FULL;
      end else if (adv) begin
        if (feed_occ) next_mb <= next_mb + MBW'(1);
        if (finish) begin
          active     <= 1'b0;
          frame_done <= 1'b1;
        end
      end
    end
  end

  // R8
  feed_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (next_mb <= total_q));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !active);
endmodule

// File: rtl/mbp_bufsel.sv
module mbp_bufsel #(
  parameter int NB = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [NB-1:0] sel
);
  for (genvar b = 0; b < NB; b++) begin : g_bound
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sel[b] <= 1'b0;
      else if (adv) sel[b] <= ~sel[b];
    end
  end
endmodule

// File: rtl/mb_pipe_sched.sv
module mb_pipe_sched
  import mbp_pkg::*;
#(
  parameter int MBW = 14
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frame_start,
  input  logic [MBW-1:0]           frame_mbs,
  input  logic                     two_stage,
  input  logic [NUM_SLOTS-1:0]     stage_done,
  output logic [NUM_SLOTS-1:0]     stage_start,
  output logic [NUM_SLOTS-1:0]     stage_busy,
  output logic [NUM_SLOTS*MBW-1:0] stage_mb,
  output logic [NUM_BOUNDS-1:0]    buf_sel,
  output logic                     frame_busy,
  output logic                     frame_done
);
  logic [NUM_SLOTS-1:0] occ, fin, start, in_occ;
  logic [MBW-1:0]       mb    [NUM_SLOTS];
  logic [MBW-1:0]       in_mb [NUM_SLOTS];
  logic                 adv, active, feed_occ;
  logic                 tail_occ;
  logic [MBW-1:0]       tail_mb, next_mb;
  pipe_mode_e           mode_q;

  assign tail_occ = (mode_q == PIPE_SHORT) ? occ[SHORT_SLOTS-1] : occ[NUM_SLOTS-1];
  assign tail_mb  = (mode_q == PIPE_SHORT) ? mb[SHORT_SLOTS-1]  : mb[NUM_SLOTS-1];

  mbp_frame_ctrl #(.MBW(MBW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .frame_mbs  (frame_mbs),
    .two_stage  (two_stage),
    .occ        (occ),
    .fin        (fin),
    .tail_occ   (tail_occ),
    .tail_mb    (tail_mb),
    .adv        (adv),
    .active     (active),
    .mode_q     (mode_q),
    .next_mb    (next_mb),
    .feed_occ   (feed_occ),
    .frame_done (frame_done)
  );

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    if (i == 0) begin : g_head
      assign in_occ[i] = feed_occ;
      assign in_mb[i]  = next_mb;
    end else if (i < SHORT_SLOTS) begin : g_core
      assign in_occ[i] = occ[i-1];
      assign in_mb[i]  = mb[i-1];
    end else begin : g_ext
      assign in_occ[i] = occ[i-1] & (mode_q == PIPE_FULL);
      assign in_mb[i]  = mb[i-1];
    end

    mbp_slot #(.MBW(MBW)) u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (adv),
      .in_occ(in_occ[i]),
      .in_mb (in_mb[i]),
      .done  (stage_done[i]),
      .occ   (occ[i]),
      .mb    (mb[i]),
      .fin   (fin[i]),
      .start (start[i])
    );

    assign stage_mb[i*MBW +: MBW] = mb[i];
  end

  mbp_bufsel #(.NB(NUM_BOUNDS)) u_bufsel (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (adv),
    .sel  (buf_sel)
  );

  assign stage_start = start;
  assign stage_busy  = occ;
  assign frame_busy  = active;

  // R3
  lockstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|stage_start) |-> $past(&(~occ | fin)));

  // R6
  short_slots_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PIPE_SHORT) |-> (occ[NUM_SLOTS-1:SHORT_SLOTS] == '0));

  // R9
  buf_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|stage_start) |-> (buf_sel == ~$past(buf_sel)));

  // R4
  slot_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start[0] && start[1]) |-> (mb[1] + MBW'(1) == mb[0]));
endmodule

// File: tb/mb_pipe_sched_bench.sv
module mb_pipe_sched_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MBW = 14;
  localparam int NS = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            frame_start = 1'b0;
  logic [MBW-1:0]  frame_mbs = '0;
  logic            two_stage = 1'b0;
  logic [NS-1:0]   stage_done = '0;
  logic [NS-1:0]   stage_start, stage_busy;
  logic [NS*MBW-1:0] stage_mb;
  logic [2:0]      buf_sel;
  logic            frame_busy, frame_done;

  int cyc = 0;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mb_pipe_sched #(.MBW(MBW)) u_mb_pipe_sched (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_mbs(frame_mbs),
    .two_stage(two_stage), .stage_done(stage_done), .stage_start(stage_start),
    .stage_busy(stage_busy), .stage_mb(stage_mb), .buf_sel(buf_sel),
    .frame_busy(frame_busy), .frame_done(frame_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_advances(input int n, input bit two);
    return n + (two ? 2 : 4);
  endfunction

  function automatic logic [2:0] exp_bufsel(input logic [2:0] b0, input int n, input bit two);
    return (exp_advances(n, two) % 2 == 1) ? ~b0 : b0;
  endfunction

  task automatic run_frame(input int n, input bit two, input bit glitch,
                           input bit noise, input bit restart_mid);
    int cnt[NS];
    int exp_mb[NS];
    int bad = 0;
    int dones = 0;
    int waitc = 0;
    int last_ref;
    int t0;
    bit seen4 = 0;
    logic [2:0] sb0;
    sb0 = buf_sel;
    for (int i = 0; i < NS; i++) begin cnt[i] = 0; exp_mb[i] = 0; end
    @(negedge clk);
    frame_mbs = MBW'(n);
    two_stage = two;
    frame_start = 1'b1;
    last_ref = cyc;
    t0 = cyc;
    forever begin
      @(negedge clk);
      frame_start = 1'b0;
      stage_done = '0;
      if (noise) two_stage = ~two_stage;
      if (cyc == t0 + 1) chk(frame_busy == 1'b1, "R2", "frame_busy after accept", frame_busy, 1);
      if (restart_mid && cyc == t0 + 9) begin
        frame_start = 1'b1;
        frame_mbs = MBW'(n + 3);
      end
      for (int i = 0; i < NS; i++) begin
        if (cnt[i] > 0) begin
          cnt[i]--;
          if (cnt[i] == 0) begin stage_done[i] = 1'b1; last_ref = cyc; end
        end
      end
      if (|stage_start) begin
        chk(cyc == last_ref + 2, "R3", "start cycle after last done", cyc, last_ref + 2);
        if (stage_start == 4'hF &&
            stage_mb[0 +: MBW] == stage_mb[MBW +: MBW] + 1 &&
            stage_mb[MBW +: MBW] == stage_mb[2*MBW +: MBW] + 1 &&
            stage_mb[2*MBW +: MBW] == stage_mb[3*MBW +: MBW] + 1)
          seen4 = 1;
        for (int i = 0; i < NS; i++) begin
          if (stage_start[i]) begin
            if (two && i >= 2) bad++;
            else begin
              chk(stage_mb[i*MBW +: MBW] == MBW'(exp_mb[i]), "R4", "slot index order",
                  stage_mb[i*MBW +: MBW], exp_mb[i]);
              chk(stage_busy[i], "R4", "busy while started", stage_busy[i], 1);
              exp_mb[i]++;
            end
            cnt[i] = 1 + int'($urandom % 5);
            if (glitch && i == 0) stage_done[0] = 1'b1; // R7 done in start cycle
          end
        end
      end
      if (noise && two) begin
        stage_done[2] = 1'($urandom % 2);
        stage_done[3] = 1'($urandom % 2);
      end
      if (two) chk(stage_busy[3:2] == 2'b00, "R6", "upper slots idle", stage_busy[3:2], 0);
      if (frame_done) begin
        dones++;
        chk(cyc == last_ref + 2, "R10", "frame_done timing", cyc, last_ref + 2);
        chk(stage_busy == '0, "R8", "drained at frame_done", stage_busy, 0);
        break;
      end
      waitc++;
      if (waitc > 4000) begin
        chk(0, "R10", "watchdog frame end", waitc, 4000);
        break;
      end
    end
    stage_done = '0;
    frame_start = 1'b0;
    for (int i = 0; i < (two ? 2 : NS); i++)
      chk(exp_mb[i] == n, "R4", "indices per slot", exp_mb[i], n);
    chk(bad == 0, "R6", "starts on upper slots", bad, 0);
    chk(dones == 1, "R10", "frame_done count", dones, 1);
    if (!two && n >= 4) chk(seen4, "R5", "four in flight", seen4, 1);
    chk(buf_sel == exp_bufsel(sb0, n, two), "R9", "buf_sel flips", buf_sel, exp_bufsel(sb0, n, two));
    @(negedge clk);
    chk(frame_done == 1'b0 && frame_busy == 1'b0, "R10", "idle after frame",
        {frame_done, frame_busy}, 0);
  endtask

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    chk(stage_start == '0 && stage_busy == '0, "R1", "slots in reset", {stage_start, stage_busy}, 0);
    chk(buf_sel == '0, "R1", "buf_sel in reset", buf_sel, 0);
    chk(frame_busy == 0 && frame_done == 0, "R1", "frame flags in reset", {frame_busy, frame_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(stage_start == '0 && frame_busy == 0, "R1", "idle after reset", {stage_start, frame_busy}, 0);

    frame_mbs = '0;
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(stage_start == '0 && frame_busy == 0, "R2", "zero-length ignored", {stage_start, frame_busy}, 0);
    end

    run_frame(1, 0, 0, 0, 0);
    run_frame(1, 1, 0, 0, 0);
    run_frame(3, 0, 0, 0, 0);   // R8 shorter than pipeline
    run_frame(10, 0, 0, 0, 0);
    run_frame(7, 1, 0, 1, 0);   // R6 R2 noise and mode toggling
    run_frame(6, 0, 1, 1, 1);   // R7 glitch, R2 restart ignored
    for (int f = 0; f < 6; f++)
      run_frame(1 + int'($urandom % 20), 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    chk(0, "R10", "global watchdog", cyc, 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule